// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the cache controller of one processor that shares a memory bus with other caches. It is direct-mapped, and each line holds a single data word. Every line is invalid, clean or dirty. The processor issues reads and writes on a request port, and the port holds the processor until the access finishes. Every bus transaction is started by this controller as bus master: a fill on a read miss, a write-through, or a write-back of a dirty victim.

A write to a line that is not yet dirty goes out on the bus once. Memory is updated, the other caches drop their copies, and the local line becomes dirty. Writes to a line that is already dirty stay inside the cache. The controller also watches the transactions of the other caches on a snoop port. If it holds the snooped word dirty, it stops memory from answering and drives the word itself. A remote read then leaves the local line clean. A remote write leaves it invalid, so the writer holds the only valid copy.

Top module: `wocache_top`

## Requirements
- R1: A read that hits a valid line with a matching tag raises `cpu_ready` for one cycle, one clock after the request is accepted, with the stored word on `cpu_rdata` and no bus transaction.
- R2: A read miss issues one bus transaction with `bus_op` = 0 (read) at the request address. The cycle after `bus_done`, `cpu_ready` rises with the word taken from `bus_rdata`, and the line becomes clean.
- R3: A write to a clean line, or a write miss, issues one bus transaction with `bus_op` = 1 (write-through) carrying the address and the data. The line then becomes dirty.
- R4: A write to a dirty line with a matching tag updates the line locally, completes one clock after acceptance, and raises no `bus_req`.
- R5: While `snp_valid` is high and the snooped address hits a dirty line, `snp_inhibit` is high and `snp_data` carries the stored word in the same cycle. A snoop that misses, or that hits a clean line, leaves `snp_inhibit` low.
- R6: A remote write snoop (`snp_write` = 1) that hits a valid line invalidates it. The next local access to that address misses.
- R7: A remote read snoop that hits a dirty line leaves the line clean, so the next local write goes out on the bus again. A remote read snoop of a clean line leaves the line clean, and a later local read hits.
- R8: A miss whose line index holds a dirty word of another tag first issues a write-back with `bus_op` = 2 for the victim address and data. The fill or write-through for the new address follows.
- R9: `cpu_ready` stays low while `bus_req` is high. `bus_req`, `bus_op`, `bus_addr` and `bus_wdata` hold steady until `bus_done`.
- R10: A request that arrives in the same cycle as a snoop is not accepted in that cycle. The snoop's effect on the line is applied first, and the request sees it.
- R11: After reset every line is invalid, and `cpu_ready`, `bus_req` and `snp_inhibit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction pending |
| bus_op | output | 2 | 0 read, 1 write-through, 2 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Transaction write data |
| bus_done | input | 1 | Transaction complete, one cycle |
| bus_rdata | input | DW | Read data, valid with `bus_done` |
| snp_valid | input | 1 | A remote transaction is on the bus |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | AW | Remote transaction address |
| snp_inhibit | output | 1 | Memory must not answer |
| snp_data | output | DW | Word supplied by this cache |

## Verification
Assertions check, on every cycle, that the bus request holds steady until it completes and that the processor is never released during a transaction. They also check that a fill returns the bus word one cycle later, that a write to a dirty line raises no bus request, and that a dirty word is supplied no more than once before the line leaves the dirty state. Only the bench scenarios can show that the line states are right. This covers whether a line is clean, dirty or invalid after a snoop, the ordering of a write-back before a fill, and the snoop-first rule when a request and a snoop arrive together. These need a model of every line's tag, state and data, and a model of memory.

// File: rtl/wocache_pkg.sv
`timescale 1ns/1ps
// Shared types for the write-once cache controller.
package wocache_pkg;
    typedef enum logic [1:0] {
        LS_INVALID = 2'd0,
        LS_CLEAN   = 2'd1,
        LS_DIRTY   = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BOP_READ  = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_WBACK = 2'd2
    } bus_op_e;
endpackage

// File: rtl/wocache_store.sv
`timescale 1ns/1ps
// Line storage: per-line state, tag and data, with two read ports (CPU and
// snoop index) and two write ports. Assumes the snoop update and the
// controller fill never target the same line in one cycle. If they do,
// the fill wins.
module wocache_store
    import wocache_pkg::*;
#(
    parameter int IW = 4,
    parameter int TW = 4,
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IW-1:0]       cpu_idx,
    output line_state_e         cpu_state,
    output logic [TW-1:0]       cpu_tag,
    output logic [DW-1:0]       cpu_data,
    input  logic [IW-1:0]       snp_idx,
    output line_state_e         snp_state,
    output logic [TW-1:0]       snp_tag,
    output logic [DW-1:0]       snp_data,
    input  logic                snp_upd_en,
    input  line_state_e         snp_upd_state,
    input  logic                fill_en,
    input  logic [IW-1:0]       fill_idx,
    input  logic [TW-1:0]       fill_tag,
    input  logic [DW-1:0]       fill_data,
    input  line_state_e         fill_state
);
    localparam int LINES = 1 << IW;

    line_state_e       state_q [LINES];
    logic [TW-1:0]     tag_q   [LINES];
    logic [DW-1:0]     data_q  [LINES];

    // Line states: reset to invalid, then the snoop update and the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) state_q[i] <= LS_INVALID;
        end else begin
            if (snp_upd_en) state_q[snp_idx] <= snp_upd_state;
            if (fill_en)    state_q[fill_idx] <= fill_state;
        end
    end

    // Tag and data payload: written by the fill only.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_data;
        end
    end

    // Read ports.
    always_comb begin
        cpu_state = state_q[cpu_idx];
        cpu_tag   = tag_q[cpu_idx];
        cpu_data  = data_q[cpu_idx];
        snp_state = state_q[snp_idx];
        snp_tag   = tag_q[snp_idx];
        snp_data  = data_q[snp_idx];
    end
endmodule

// File: rtl/wocache_snoop.sv
`timescale 1ns/1ps
// Snoop responder: compares a remote transaction with the addressed line.
// On a dirty hit it inhibits memory and supplies the word. It then moves
// the line to clean (remote read) or invalid (remote write). A clean hit
// is invalidated only by a remote write. Purely combinational.
module wocache_snoop
    import wocache_pkg::*;
#(
    parameter int TW = 4,
    parameter int DW = 16
) (
    input  logic            snp_valid,
    input  logic            snp_write,
    input  logic [TW-1:0]   snp_tag,
    input  line_state_e     line_state,
    input  logic [TW-1:0]   line_tag,
    input  logic [DW-1:0]   line_data,
    output logic            inhibit,
    output logic [DW-1:0]   supply_data,
    output logic            upd_en,
    output line_state_e     upd_state
);
    logic hit;

    // Hit decision and the resulting response and state change.
    always_comb begin
        hit         = snp_valid && (line_state != LS_INVALID) && (line_tag == snp_tag);
        inhibit     = hit && (line_state == LS_DIRTY);
        supply_data = inhibit ? line_data : '0;
        upd_en      = hit && (snp_write || (line_state == LS_DIRTY));
        upd_state   = snp_write ? LS_INVALID : LS_CLEAN;
    end
endmodule

// File: rtl/wocache_ctrl.sv
`timescale 1ns/1ps
// Request sequencer: accepts one CPU request at a time when no snoop is
// present, answers hits directly, and otherwise runs an optional victim
// write-back followed by a fill or write-through on the bus. Assumes the
// CPU holds its request stable until cpu_ready, and that bus_done arrives
// only while bus_req is high.
module wocache_ctrl
    import wocache_pkg::*;
#(
    parameter int AW = 8,
    parameter int IW = 4,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic            cpu_ready,
    output logic [DW-1:0]   cpu_rdata,
    input  logic            snp_valid,
    input  line_state_e     line_state,
    input  logic [AW-IW-1:0] line_tag,
    input  logic [DW-1:0]   line_data,
    output logic            bus_req,
    output logic [1:0]      bus_op,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic            bus_done,
    input  logic [DW-1:0]   bus_rdata,
    output logic            fill_en,
    output logic [IW-1:0]   fill_idx,
    output logic [AW-IW-1:0] fill_tag,
    output logic [DW-1:0]   fill_data,
    output line_state_e     fill_state
);
    localparam int TW = AW - IW;

    typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_XFER, ST_DONE} seq_e;

    seq_e            st_q;
    logic            req_we_q;
    logic [AW-1:0]   req_addr_q;
    logic [DW-1:0]   req_wdata_q;
    bus_op_e         op_q;
    logic [AW-1:0]   baddr_q;
    logic [DW-1:0]   bdata_q;
    logic            ready_q;
    logic [DW-1:0]   rdata_q;

    logic            accept;
    logic            hit;
    logic            dirty_hit;
    logic [TW-1:0]   cpu_tag;

    // Request decode against the addressed line.
    always_comb begin
        cpu_tag   = cpu_addr[AW-1:IW];
        hit       = (line_state != LS_INVALID) && (line_tag == cpu_tag);
        dirty_hit = hit && (line_state == LS_DIRTY);
        accept    = (st_q == ST_IDLE) && cpu_req && !snp_valid;
    end

    // Line write port: local dirty write, victim release, fill install.
    always_comb begin
        fill_en    = 1'b0;
        fill_idx   = req_addr_q[IW-1:0];
        fill_tag   = req_addr_q[AW-1:IW];
        fill_data  = req_we_q ? req_wdata_q : bus_rdata;
        fill_state = req_we_q ? LS_DIRTY : LS_CLEAN;
        unique case (st_q)
            ST_IDLE: begin
                fill_idx  = cpu_addr[IW-1:0];
                fill_tag  = cpu_tag;
                fill_data = cpu_wdata;
                fill_state = LS_DIRTY;
                fill_en   = accept && cpu_we && dirty_hit;
            end
            ST_WBACK: begin
                fill_tag   = baddr_q[AW-1:IW];
                fill_data  = bdata_q;
                fill_state = LS_INVALID;
                fill_en    = bus_done;
            end
            ST_XFER:  fill_en = bus_done;
            default:  fill_en = 1'b0;
        endcase
    end

    // Sequencer state, bus transaction registers and CPU response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            op_q        <= BOP_READ;
            baddr_q     <= '0;
            bdata_q     <= '0;
            ready_q     <= 1'b0;
            rdata_q     <= '0;
        end else begin
            ready_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    req_we_q    <= cpu_we;
                    req_addr_q  <= cpu_addr;
                    req_wdata_q <= cpu_wdata;
                    if (hit && !cpu_we) begin
                        rdata_q <= line_data;
                        ready_q <= 1'b1;
                        st_q    <= ST_DONE;
                    end else if (cpu_we && dirty_hit) begin
                        rdata_q <= cpu_wdata;
                        ready_q <= 1'b1;
                        st_q    <= ST_DONE;
                    end else if (!hit && line_state == LS_DIRTY) begin
                        op_q    <= BOP_WBACK;
                        baddr_q <= {line_tag, cpu_addr[IW-1:0]};
                        bdata_q <= line_data;
                        st_q    <= ST_WBACK;
                    end else begin
                        op_q    <= cpu_we ? BOP_WRITE : BOP_READ;
                        baddr_q <= cpu_addr;
                        bdata_q <= cpu_wdata;
                        st_q    <= ST_XFER;
                    end
                end
                ST_WBACK: if (bus_done) begin
                    op_q    <= req_we_q ? BOP_WRITE : BOP_READ;
                    baddr_q <= req_addr_q;
                    bdata_q <= req_wdata_q;
                    st_q    <= ST_XFER;
                end
                ST_XFER: if (bus_done) begin
                    rdata_q <= req_we_q ? req_wdata_q : bus_rdata;
                    ready_q <= 1'b1;
                    st_q    <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (st_q == ST_WBACK) || (st_q == ST_XFER);
    assign bus_op    = op_q;
    assign bus_addr  = baddr_q;
    assign bus_wdata = bdata_q;
    assign cpu_ready = ready_q;
    assign cpu_rdata = rdata_q;

    // R9: a pending transaction keeps its fields until completion.
    a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_op) && $stable(bus_wdata));

    // R9: the processor is never released while the bus is busy.
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    // R2: a completed fill returns the bus word to the processor next cycle.
    a_r2_fill_return: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done && bus_op == 2'd0 |=> cpu_ready && cpu_rdata == $past(bus_rdata));

    // R4: a write to a dirty line completes without any bus request.
    a_r4_dirty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cpu_we && dirty_hit |=> cpu_ready && !bus_req);
endmodule

// File: rtl/wocache_top.sv
`timescale 1ns/1ps
// Write-once snooping cache controller, direct-mapped with one-word lines.
// Assumes bus arbitration outside the block serialises this cache's own
// transactions with the remote ones it snoops.
module wocache_top
    import wocache_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int LINES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic            cpu_ready,
    output logic [DW-1:0]   cpu_rdata,
    output logic            bus_req,
    output logic [1:0]      bus_op,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic            bus_done,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            snp_valid,
    input  logic            snp_write,
    input  logic [AW-1:0]   snp_addr,
    output logic            snp_inhibit,
    output logic [DW-1:0]   snp_data
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    line_state_e    c_state, s_state, s_upd_state, f_state;
    logic [TW-1:0]  c_tag, s_tag, f_tag;
    logic [DW-1:0]  c_data, s_data, f_data;
    logic           s_upd_en, f_en;
    logic [IW-1:0]  f_idx;

    wocache_store #(.IW(IW), .TW(TW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cpu_idx(cpu_addr[IW-1:0]), .cpu_state(c_state), .cpu_tag(c_tag), .cpu_data(c_data),
        .snp_idx(snp_addr[IW-1:0]), .snp_state(s_state), .snp_tag(s_tag), .snp_data(s_data),
        .snp_upd_en(s_upd_en), .snp_upd_state(s_upd_state),
        .fill_en(f_en), .fill_idx(f_idx), .fill_tag(f_tag), .fill_data(f_data), .fill_state(f_state)
    );

    wocache_snoop #(.TW(TW), .DW(DW)) u_snoop (
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_tag(snp_addr[AW-1:IW]),
        .line_state(s_state), .line_tag(s_tag), .line_data(s_data),
        .inhibit(snp_inhibit), .supply_data(snp_data),
        .upd_en(s_upd_en), .upd_state(s_upd_state)
    );

    wocache_ctrl #(.AW(AW), .IW(IW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .snp_valid(snp_valid),
        .line_state(c_state), .line_tag(c_tag), .line_data(c_data),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .fill_en(f_en), .fill_idx(f_idx), .fill_tag(f_tag), .fill_data(f_data), .fill_state(f_state)
    );

    // R7 / R6: once a dirty word is supplied, the line is no longer dirty.
    a_r7_supply_once: assert property (@(posedge clk) disable iff (!rst_n)
        snp_inhibit && !bus_done |=> !(snp_inhibit && snp_addr == $past(snp_addr)));
endmodule

// File: tb/wocache_top_tb.sv
`timescale 1ns/1ps
module wocache_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0;
    logic [7:0]  cpu_addr = 0;
    logic [15:0] cpu_wdata = 0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_done = 0;
    logic [15:0] bus_rdata = 0;
    logic        snp_valid = 0, snp_write = 0;
    logic [7:0]  snp_addr = 0;
    logic        snp_inhibit;
    logic [15:0] snp_data;

    int compared = 0;
    int mismatched = 0;

    // Reference model: memory as seen by the rest of the system, plus lines.
    logic [15:0] mem    [256];
    int          mstate [16];   // 0 invalid, 1 clean, 2 dirty
    logic [3:0]  mtag   [16];
    logic [15:0] mdata  [16];

    always #10 clk = ~clk;

    wocache_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_inhibit(snp_inhibit), .snp_data(snp_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model effect of a snoop; returns the expected response.
    task automatic snoop_model(input bit w, input logic [7:0] a, input logic [15:0] v,
                               output bit inh, output logic [15:0] d);
        int  i = int'(a[3:0]);
        bit  hit = (mstate[i] != 0) && (mtag[i] == a[7:4]);
        inh = hit && (mstate[i] == 2);
        d   = inh ? mdata[i] : 16'h0;
        if (hit && w) mstate[i] = 0;
        else if (inh) begin mstate[i] = 1; mem[a] = mdata[i]; end
        if (w) mem[a] = v;
    endtask

    // A lone remote transaction for one cycle.
    task automatic snoop(input bit w, input logic [7:0] a, input logic [15:0] v, input string req);
        bit inh; logic [15:0] d;
        @(negedge clk);
        snp_valid = 1; snp_write = w; snp_addr = a;
        snoop_model(w, a, v, inh, d);
        #1;
        check(snp_inhibit == inh, req, "snp_inhibit", 32'(snp_inhibit), 32'(inh));
        if (inh) check(snp_data == d, req, "snp_data", 32'(snp_data), 32'(d));
        @(negedge clk);
        snp_valid = 0;
    endtask

    // One CPU access, optionally with a snoop in its first cycle.
    task automatic access(input bit we, input logic [7:0] a, input logic [15:0] wd,
                          input bit pre, input bit pw, input logic [7:0] pa,
                          input logic [15:0] pv, input string req);
        logic [1:0]  qop [$];
        logic [7:0]  qa  [$];
        logic [15:0] qd  [$];
        logic [15:0] ex_rd;
        bit inh; logic [15:0] d;
        int i, cyc;
        bit hit, done;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (pre) begin
            snp_valid = 1; snp_write = pw; snp_addr = pa;
            snoop_model(pw, pa, pv, inh, d);
            #1;
            check(snp_inhibit == inh, "R10", "snp_inhibit with request", 32'(snp_inhibit), 32'(inh));
        end
        i = int'(a[3:0]);
        hit = (mstate[i] != 0) && (mtag[i] == a[7:4]);
        ex_rd = mdata[i];
        if (!we && hit) begin
        end else if (we && hit && mstate[i] == 2) begin
            mdata[i] = wd;
        end else begin
            if (!hit && mstate[i] == 2) begin
                qop.push_back(2'd2); qa.push_back({mtag[i], a[3:0]}); qd.push_back(mdata[i]);
                mem[{mtag[i], a[3:0]}] = mdata[i];
            end
            qop.push_back(we ? 2'd1 : 2'd0); qa.push_back(a); qd.push_back(wd);
            if (we) begin mem[a] = wd; mstate[i] = 2; mdata[i] = wd; end
            else    begin mstate[i] = 1; mdata[i] = mem[a]; ex_rd = mem[a]; end
            mtag[i] = a[7:4];
        end
        cyc = 0; done = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            snp_valid = 0;
            bus_done  = 0;
            if (cpu_ready) begin
                done = 1;
                cpu_req = 0;
                if (!we) check(cpu_rdata == ex_rd, req, "cpu_rdata", 32'(cpu_rdata), 32'(ex_rd));
            end else if (bus_req) begin
                if (qop.size() == 0) begin
                    check(0, req, "unexpected bus_op", 32'(bus_op), 32'hFFFF);
                end else begin
                    check(bus_op == qop[0], req, "bus_op", 32'(bus_op), 32'(qop[0]));
                    check(bus_addr == qa[0], req, "bus_addr", 32'(bus_addr), 32'(qa[0]));
                    if (qop[0] != 2'd0)
                        check(bus_wdata == qd[0], req, "bus_wdata", 32'(bus_wdata), 32'(qd[0]));
                    void'(qop.pop_front()); void'(qa.pop_front()); void'(qd.pop_front());
                end
                bus_rdata = mem[bus_addr];
                bus_done  = 1;
            end
        end
        if (!done) begin
            cpu_req = 0; bus_done = 0;
            check(0, "R9", "cpu_ready never rose", 32'(0), 32'(1));
        end
        check(qop.size() == 0, req, "missing bus transactions", 32'(qop.size()), 32'(0));
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        compared++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'(k * 16'h0101) ^ 16'h5A00;
        for (int k = 0; k < 16; k++) begin mstate[k] = 0; mtag[k] = 0; mdata[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state.
        check(cpu_ready == 0, "R11", "cpu_ready after reset", 32'(cpu_ready), 0);
        check(bus_req == 0, "R11", "bus_req after reset", 32'(bus_req), 0);
        snoop(0, 8'h05, 0, "R11");
        // R2 then R1.
        access(0, 8'h13, 0, 0, 0, 0, 0, "R2");
        access(0, 8'h13, 0, 0, 0, 0, 0, "R1");
        // R3 first write goes through, R4 second stays local.
        access(1, 8'h13, 16'hBEEF, 0, 0, 0, 0, "R3");
        access(1, 8'h13, 16'hCAFE, 0, 0, 0, 0, "R4");
        access(0, 8'h13, 0, 0, 0, 0, 0, "R4");
        // R5 supply on remote read, R7 line returns to clean.
        snoop(0, 8'h13, 0, "R5");
        access(1, 8'h13, 16'h1234, 0, 0, 0, 0, "R7");
        // R6 remote write on a dirty line: supply, then invalidate.
        snoop(1, 8'h13, 16'h7777, "R6");
        access(0, 8'h13, 0, 0, 0, 0, 0, "R6");
        // R7 remote read on a clean line.
        snoop(0, 8'h13, 0, "R7");
        access(0, 8'h13, 0, 0, 0, 0, 0, "R7");
        // R5 snoop with a different tag on the same index.
        access(1, 8'h25, 16'hA5A5, 0, 0, 0, 0, "R3");
        snoop(0, 8'h35, 0, "R5");
        // R8 dirty victim written back before the fill.
        access(0, 8'h35, 0, 0, 0, 0, 0, "R8");
        access(1, 8'h45, 16'h4545, 0, 0, 0, 0, "R3");
        access(1, 8'h55, 16'h5555, 0, 0, 0, 0, "R8");
        // R10 snoop and request in the same cycle.
        access(0, 8'h55, 0, 1, 1, 8'h55, 16'h0F0F, "R10");
        access(1, 8'h66, 16'h6666, 0, 0, 0, 0, "R3");
        access(0, 8'h66, 0, 1, 0, 8'h66, 0, "R10");
        // Mixed traffic on a few lines.
        for (int n = 0; n < 120; n++) begin
            logic [7:0] ra;
            ra = {2'b00, 2'(($urandom) % 3), 2'b01, 2'(($urandom) % 2)};
            case ($urandom % 4)
                0: access(0, ra, 0, 0, 0, 0, 0, "R1");
                1: access(1, ra, 16'($urandom), 0, 0, 0, 0, "R3");
                2: snoop($urandom % 2 == 1, ra, 16'($urandom), "R5");
                default: access($urandom % 2 == 1, ra, 16'($urandom), 1,
                                $urandom % 2 == 1, ra ^ 8'h10, 16'($urandom), "R10");
            endcase
        end
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule